// File: doc/BRIEF.md
# Coprocessor Operation Control Sequencer

This block sequences the operations of a convolutional codec and channel equalizer coprocessor. A host writes a control word that holds three operation enables (decode, encode, equalize), a flush enable and a continuous-mode bit. It also loads a symbol counter and a flush-path select value. While an operation runs, the block holds a run enable towards an abstract datapath. It counts one symbol down for each step-done pulse that comes back.

When the count runs out, a decode or equalize job in normal mode starts a flush phase. It issues a flush-start strobe and waits for the datapath's flush-done before it clears its own enable bit. An encode job clears its enable as soon as the count reaches zero and runs no flush. In continuous mode there is no automatic flush and the operation enables are never cleared by hardware. The host can end a job early by setting the flush enable. Clearing an operation enable freezes the sequencer in place, and setting the same bit again resumes from that point.

Top module: `codec_op_seq`

## Requirements
- R1: The control word has these bits: bit 2 decode enable, bit 3 encode enable, bit 4 equalize enable, bit 5 flush enable, bit 6 continuous mode. Bits 0, 1 and 7 are stored without effect. `ctrl_rd` returns the register one cycle after a host write. Reset clears the control word, the counter and all strobes.
- R2: While an operation runs, `run_en` is high and each `step_done` pulse lowers the counter by one. The counter never goes below zero.
- R3: For decode or equalize in normal mode, the cycle after the counter reads zero brings a one-cycle `flush_start`. The enable bit stays set until `flush_done` is seen, and it clears on the edge that samples `flush_done`.
- R4: For encode in normal mode, the encode enable clears on the first edge at which the counter reads zero, with no `flush_start`.
- R5: With continuous mode set, a zero count starts no flush and clears no operation enable.
- R6: When the host clears the active enable, the counter and the phase are held. `step_done` and `flush_done` are ignored and `run_en` is low.
- R7: Setting the same enable again resumes from the held count or flush phase, and `flush_start` is not issued a second time.
- R8: Setting the flush enable during decode or equalize starts a flush before the count expires. On `flush_done`, the flush enable and (in normal mode) the operation enable clear; in continuous mode only the flush enable clears. With encode, the flush enable ends the job at once without a flush.
- R9: `flush_path` presents the value last written through the path-select port.
- R10: When several operation enables are set, only one runs, in the order decode, encode, equalize. `conflict_err` is high from the second cycle after such a word is loaded.
- R11: A host write on the same edge as a hardware clear wins: the written value is stored.
- R12: `done_pulse` is high for the cycle after each edge at which hardware clears a control bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Control word write strobe |
| host_wdata | input | CTRL_W | Control word write value |
| cnt_wr | input | 1 | Symbol counter load strobe |
| cnt_wdata | input | CNT_W | Symbol counter load value |
| path_wr | input | 1 | Flush path select write strobe |
| path_wdata | input | PATH_W | Flush path select value |
| step_done | input | 1 | Datapath finished one symbol |
| flush_done | input | 1 | Datapath finished the flush |
| ctrl_rd | output | CTRL_W | Control word readback |
| cnt_rd | output | CNT_W | Symbol counter readback |
| run_en | output | 1 | Datapath may process symbols |
| flush_start | output | 1 | One-cycle flush request |
| flush_path | output | PATH_W | Path used by the flush |
| done_pulse | output | 1 | Hardware cleared a control bit |
| conflict_err | output | 1 | More than one operation enable set |

## Verification
The bench builds the block with an 8-bit counter and a 4-bit path select, and keeps the control word at its default 8 bits. With these values, short counts of one to five symbols reach zero within a few cycles, so every end-of-count path can be driven in turn. These paths are the flush on decode and equalize, the immediate clear on encode, continuous mode, early flush, halt in both phases, and a host write that meets a hardware clear. The 4-bit path value is easy to compare exactly on `flush_path`.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int DEC_BIT  = 2;
  localparam int ENC_BIT  = 3;
  localparam int EQ_BIT   = 4;
  localparam int FLEN_BIT = 5;
  localparam int CONT_BIT = 6;
  localparam int N_OPS    = 3;
  localparam int OP_LSB   = DEC_BIT;

  typedef enum logic {
    PH_RUN   = 1'b0,
    PH_FLUSH = 1'b1
  } phase_t;
endpackage

// File: rtl/cs_op_arbiter.sv
module cs_op_arbiter #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         conflict
);
  // lowest index wins: loop from the top so lower indices override
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

  assign conflict = ($countones(req) > 1);

  p_single_grant_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));
  p_grant_from_req_r10: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> (grant != '0));
endmodule

// File: rtl/cs_sym_counter.sv
module cs_sym_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] cnt_q,
  output logic         zero
);
  assign zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (ld)           cnt_q <= ld_val;
    else if (step && !zero) cnt_q <= cnt_q - 1'b1;
  end

  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(step) && !$past(ld) && ($past(cnt_q) != '0))
      |-> (cnt_q == $past(cnt_q) - 1'b1));
  p_floor_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_q) == '0 && !$past(ld)) |-> (cnt_q == '0));
endmodule

// File: rtl/cs_phase_fsm.sv
module cs_phase_fsm
  import cs_pkg::*;
#(
  parameter int N  = N_OPS,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  grant,
  input  logic          flen,
  input  logic          cont,
  input  logic          zero,
  input  logic          flush_done,
  output logic          step_ok,
  output logic [CW-1:0] clr,
  output logic          flush_start_q,
  output phase_t        phase_q
);
  logic   op_valid, is_enc, go_flush;
  phase_t phase_d;

  assign op_valid = |grant;
  assign is_enc   = grant[ENC_BIT-OP_LSB];

  always_comb begin
    clr      = '0;
    step_ok  = 1'b0;
    go_flush = 1'b0;
    phase_d  = phase_q;
    if (op_valid) begin
      if (phase_q == PH_RUN) begin
        step_ok = cont || !zero;
        if (flen) begin
          if (is_enc) begin
            clr[FLEN_BIT] = 1'b1;
            if (!cont) clr[ENC_BIT] = 1'b1;
          end else begin
            go_flush = 1'b1;
          end
        end else if (zero && !cont) begin
          if (is_enc) clr[ENC_BIT] = 1'b1;
          else        go_flush = 1'b1;
        end
        if (go_flush) begin
          phase_d = PH_FLUSH;
          step_ok = 1'b0;
        end
      end else if (flush_done) begin
        clr[FLEN_BIT] = 1'b1;
        if (!cont) begin
          for (int i = 0; i < N; i++)
            if (grant[i]) clr[OP_LSB+i] = 1'b1;
        end
        phase_d = PH_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q       <= PH_RUN;
      flush_start_q <= 1'b0;
    end else begin
      phase_q       <= phase_d;
      flush_start_q <= go_flush;
    end
  end

  p_flush_once_r3: assert property (@(posedge clk) disable iff (rst)
    flush_start_q |=> !flush_start_q);
  p_flush_enters_phase_r3: assert property (@(posedge clk) disable iff (rst)
    flush_start_q |-> (phase_q == PH_FLUSH));
endmodule

// File: rtl/codec_op_seq.sv
module codec_op_seq
  import cs_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int CNT_W  = 16,
  parameter int PATH_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [CTRL_W-1:0] host_wdata,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wdata,
  input  logic              path_wr,
  input  logic [PATH_W-1:0] path_wdata,
  input  logic              step_done,
  input  logic              flush_done,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CNT_W-1:0]  cnt_rd,
  output logic              run_en,
  output logic              flush_start,
  output logic [PATH_W-1:0] flush_path,
  output logic              done_pulse,
  output logic              conflict_err
);
  localparam int OP_MSB = OP_LSB + N_OPS - 1;

  logic [CTRL_W-1:0] ctrl_q, clr;
  logic [PATH_W-1:0] path_q;
  logic [N_OPS-1:0]  grant;
  logic              conflict, zero, step_ok, op_valid, done_q, err_q;
  phase_t            phase;

  cs_op_arbiter #(.N(N_OPS)) u_arb (
    .clk(clk), .rst(rst), .req(ctrl_q[OP_MSB:OP_LSB]),
    .grant(grant), .conflict(conflict)
  );

  cs_sym_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .ld(cnt_wr), .ld_val(cnt_wdata),
    .step(step_ok && step_done), .cnt_q(cnt_rd), .zero(zero)
  );

  cs_phase_fsm #(.N(N_OPS), .CW(CTRL_W)) u_fsm (
    .clk(clk), .rst(rst), .grant(grant),
    .flen(ctrl_q[FLEN_BIT]), .cont(ctrl_q[CONT_BIT]), .zero(zero),
    .flush_done(flush_done), .step_ok(step_ok), .clr(clr),
    .flush_start_q(flush_start), .phase_q(phase)
  );

  assign op_valid = |grant;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      path_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= host_wr ? host_wdata : (ctrl_q & ~clr);
      if (path_wr) path_q <= path_wdata;
      done_q <= |clr;
      err_q  <= conflict;
    end
  end

  assign ctrl_rd      = ctrl_q;
  assign flush_path   = path_q;
  assign done_pulse   = done_q;
  assign conflict_err = err_q;
  assign run_en       = step_ok;

  p_halt_holds_count_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(op_valid) && !$past(cnt_wr)) |-> $stable(cnt_rd));
  p_halt_holds_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(op_valid) |-> (phase == $past(phase)));
  p_dec_clear_after_flush_r3: assert property (@(posedge clk) disable iff (rst)
    ($fell(ctrl_q[DEC_BIT]) && !$past(host_wr)) |-> $past(flush_done));
  p_cont_keeps_ops_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[CONT_BIT]) && !$past(host_wr))
      |-> (ctrl_q[OP_MSB:OP_LSB] == $past(ctrl_q[OP_MSB:OP_LSB])));
  p_done_follows_clear_r12: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !$past(host_wr)) |-> (ctrl_q != $past(ctrl_q)));
endmodule

// File: tb/sim_codec_op_seq.sv
`timescale 1ns/1ps
module sim_codec_op_seq;
  localparam int CW = 8;
  localparam int NW = 8;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 1'b0, cnt_wr = 1'b0, path_wr = 1'b0;
  logic [CW-1:0] host_wdata = '0;
  logic [NW-1:0] cnt_wdata = '0;
  logic [PW-1:0] path_wdata = '0;
  logic step_done = 1'b0, flush_done = 1'b0;
  logic [CW-1:0] ctrl_rd;
  logic [NW-1:0] cnt_rd;
  logic run_en, flush_start, done_pulse, conflict_err;
  logic [PW-1:0] flush_path;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  codec_op_seq #(.CTRL_W(CW), .CNT_W(NW), .PATH_W(PW)) u0 (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .path_wr(path_wr),
    .path_wdata(path_wdata), .step_done(step_done), .flush_done(flush_done),
    .ctrl_rd(ctrl_rd), .cnt_rd(cnt_rd), .run_en(run_en),
    .flush_start(flush_start), .flush_path(flush_path),
    .done_pulse(done_pulse), .conflict_err(conflict_err)
  );

  // fields: [11:9] ops {eq,enc,dec}, [8] cont, [7] exp err, [6] exp flush, [5:3] ops after end
  localparam logic [11:0] VECS [6] = '{
    {3'b001, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000},
    {3'b010, 1'b0, 1'b0, 1'b0, 3'b000, 3'b000},
    {3'b100, 1'b0, 1'b0, 1'b1, 3'b000, 3'b000},
    {3'b001, 1'b1, 1'b0, 1'b0, 3'b001, 3'b000},
    {3'b100, 1'b1, 1'b0, 1'b0, 3'b100, 3'b000},
    {3'b011, 1'b0, 1'b1, 1'b1, 3'b010, 3'b000}
  };

  task automatic tick();
    @(posedge clk);
    #1;
    host_wr = 1'b0; cnt_wr = 1'b0; path_wr = 1'b0;
    step_done = 1'b0; flush_done = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [NW-1:0] n, input logic [CW-1:0] c);
    cnt_wr = 1'b1; cnt_wdata = n; host_wr = 1'b1; host_wdata = c;
    tick();
  endtask

  task automatic wr_ctrl(input logic [CW-1:0] c);
    host_wr = 1'b1; host_wdata = c;
    tick();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      step_done = 1'b1;
      tick();
    end
  endtask

  task automatic do_flush_done();
    flush_done = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: reset state
    chk("R1 reset ctrl", ctrl_rd, 0);
    chk("R1 reset cnt", cnt_rd, 0);
    chk("R1 reset flush_start", flush_start, 0);
    chk("R1 reset done", done_pulse, 0);
    chk("R1 reset err", conflict_err, 0);
    chk("R2 reset run_en", run_en, 0);

    // R1: spare bits stored, no operation
    wr_ctrl(8'h83);
    chk("R1 readback spare", ctrl_rd, 8'h83);
    chk("R1 spare no run", run_en, 0);
    wr_ctrl(8'h00);

    // R9: path select
    path_wr = 1'b1; path_wdata = 4'hA;
    tick();
    chk("R9 flush_path", flush_path, 4'hA);

    // vector table
    for (int v = 0; v < 6; v++) begin
      logic [2:0] ops, after;
      logic cont, e_err, e_fl;
      logic [2:0] e_ops;
      ops = VECS[v][11:9]; cont = VECS[v][8]; e_err = VECS[v][7];
      e_fl = VECS[v][6]; after = VECS[v][5:3];
      load(8'd3, {1'b0, cont, 1'b0, ops, 2'b00});
      steps(1);
      chk($sformatf("R2 vec%0d run_en", v), run_en, 1);
      chk($sformatf("R10 vec%0d conflict", v), conflict_err, e_err);
      steps(2);
      chk($sformatf("R2 vec%0d count zero", v), cnt_rd, 0);
      tick();
      e_ops = e_fl ? ops : after;
      chk($sformatf("R3 R4 R5 vec%0d flush_start", v), flush_start, e_fl);
      chk($sformatf("R4 R5 vec%0d ops", v), ctrl_rd[4:2], e_ops);
      chk($sformatf("R12 vec%0d done", v), done_pulse, (!e_fl && after != ops) ? 1 : 0);
      if (e_fl) begin
        chk($sformatf("R3 vec%0d still set", v), ctrl_rd[4:2], ops);
        do_flush_done();
        chk($sformatf("R3 vec%0d done", v), done_pulse, 1);
        chk($sformatf("R3 R10 vec%0d ops after", v), ctrl_rd[4:2], after);
      end
      wr_ctrl(8'h00);
      tick();
    end

    // R6/R7: halt and resume in run phase and in flush phase
    load(8'd5, 8'h04);
    steps(2);
    chk("R2 count 3", cnt_rd, 3);
    wr_ctrl(8'h00);
    steps(3);
    chk("R6 count held", cnt_rd, 3);
    chk("R6 run_en low", run_en, 0);
    wr_ctrl(8'h04);
    chk("R7 count resumed", cnt_rd, 3);
    chk("R7 run_en high", run_en, 1);
    steps(3);
    tick();
    chk("R3 flush after resume", flush_start, 1);
    wr_ctrl(8'h00);
    do_flush_done();
    chk("R6 flush_done ignored done", done_pulse, 0);
    chk("R6 flush_done ignored ctrl", ctrl_rd, 0);
    wr_ctrl(8'h04);
    chk("R7 no second flush_start", flush_start, 0);
    do_flush_done();
    chk("R7 flush completes", done_pulse, 1);
    chk("R7 dec cleared", ctrl_rd, 0);

    // R8: early flush on equalize
    load(8'd5, 8'h10);
    steps(1);
    wr_ctrl(8'h30);
    tick();
    chk("R8 early flush_start", flush_start, 1);
    chk("R9 path during flush", flush_path, 4'hA);
    do_flush_done();
    chk("R8 early done", done_pulse, 1);
    chk("R8 eq and flen cleared", ctrl_rd, 0);
    chk("R8 count kept", cnt_rd, 4);
    tick();
    chk("R12 done single cycle", done_pulse, 0);

    // R8: continuous mode, flush enable clears alone
    load(8'd5, 8'h64);
    tick();
    chk("R8 cont flush_start", flush_start, 1);
    do_flush_done();
    chk("R8 cont only flen cleared", ctrl_rd, 8'h44);
    chk("R12 cont done", done_pulse, 1);
    wr_ctrl(8'h00);

    // R8: flush enable with encode ends at once
    load(8'd5, 8'h28);
    tick();
    chk("R8 enc done", done_pulse, 1);
    chk("R8 enc cleared", ctrl_rd, 0);
    chk("R8 enc no flush", flush_start, 0);

    // R11: host write wins over hardware clear
    load(8'd1, 8'h08);
    steps(1);
    wr_ctrl(8'h48);
    chk("R11 host write wins", ctrl_rd, 8'h48);
    chk("R12 done on collision", done_pulse, 1);
    wr_ctrl(8'h00);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule